// File: doc/BRIEF.md
# Chaotic Signal Mixing Selector

This block receives the state of four chaotic oscillators, each providing an x, a y and a z coordinate as a signed fixed-point word. It reduces these twelve words to one pre-key word for a downstream keystream stage, and it does this through two levels of selection.

At the first level there is one chooser for each coordinate. The x chooser picks one oscillator's x, the y chooser picks one oscillator's y, and the z chooser picks one oscillator's z. At the second level a single chooser picks which of those three results becomes the pre-key.

The chosen word is captured in a register whenever the input strobe is high. A valid flag follows the strobe by one clock. All four select codes may change while the generator runs. They are sampled on the same edge as the data, so every output word comes from a single, consistent set of codes.

Top module: `chaos_mix_sel`

## Requirements
- R1: A synchronous active-high `rst` clears `key_word` to zero and `key_valid` to 0 on the next rising edge, even when `in_valid` is high.
- R2: With `sel_out` = 2'b00 and `in_valid` high, `key_word` after the edge equals the x word of oscillator `sel_x`. Code 0 picks bits [31:0] of `x_bus`, code 1 bits [63:32], code 2 bits [95:64] and code 3 bits [127:96].
- R3: With `sel_out` = 2'b01, `key_word` equals the y word of oscillator `sel_y`, using the same code-to-slice mapping on `y_bus`.
- R4: With `sel_out` = 2'b10, `key_word` equals the z word of oscillator `sel_z`, using the same code-to-slice mapping on `z_bus`.
- R5: `sel_out` = 2'b11 gives the same result as 2'b00, namely the x chooser's result.
- R6: `key_valid` is high in exactly the cycle that follows a rising edge on which `in_valid` was high and `rst` was low.
- R7: While `in_valid` is low, `key_word` keeps its value, whatever happens to the data buses and the select codes.
- R8: Select codes take effect on the word captured on the same edge. When the codes change on every strobed cycle, each output word matches the codes and data presented with it, with no stale or mixed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: capture a new pre-key word |
| x_bus | input | 128 | Four x words; oscillator n is in slice [32n+31:32n] |
| y_bus | input | 128 | Four y words, same layout as `x_bus` |
| z_bus | input | 128 | Four z words, same layout as `x_bus` |
| sel_x | input | 2 | x chooser: oscillator code |
| sel_y | input | 2 | y chooser: oscillator code |
| sel_z | input | 2 | z chooser: oscillator code |
| sel_out | input | 2 | Coordinate choice: 00 x, 01 y, 10 z, 11 x |
| key_word | output | 32 | Registered pre-key word |
| key_valid | output | 1 | High one cycle after an accepted strobe |

## Verification
The properties assume that the data buses and select codes are settled by the rising edge on which `in_valid` is high. They also assume that reset is held for at least one edge before any strobe. The stimulus changes all inputs only on falling edges, away from the capture edge, and it holds reset for several cycles at the start. Each oscillator's word carries its coordinate and its index in the bits, so a word taken from the wrong slice or the wrong coordinate shows up in the value itself.

// File: rtl/chaos_mix_sel.sv
module chaos_mix_sel #(
  parameter int W    = 32,
  parameter int NSRC = 4,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [NSRC*W-1:0] x_bus,
  input  logic [NSRC*W-1:0] y_bus,
  input  logic [NSRC*W-1:0] z_bus,
  input  logic [SW-1:0]     sel_x,
  input  logic [SW-1:0]     sel_y,
  input  logic [SW-1:0]     sel_z,
  input  logic [1:0]        sel_out,
  output logic [W-1:0]      key_word,
  output logic              key_valid
);

  logic [W-1:0] xs [NSRC];
  logic [W-1:0] ys [NSRC];
  logic [W-1:0] zs [NSRC];

  for (genvar n = 0; n < NSRC; n++) begin : g_split
    assign xs[n] = x_bus[n*W +: W];
    assign ys[n] = y_bus[n*W +: W];
    assign zs[n] = z_bus[n*W +: W];
  end

  logic [W-1:0] x_pick, y_pick, z_pick, pick;

  assign x_pick = xs[sel_x];
  assign y_pick = ys[sel_y];
  assign z_pick = zs[sel_z];

  always_comb begin
    case (sel_out)
      2'b01:   pick = y_pick;
      2'b10:   pick = z_pick;
      default: pick = x_pick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_word  <= '0;
      key_valid <= 1'b0;
    end else begin
      key_valid <= in_valid;
      if (in_valid) key_word <= pick;
    end
  end

endmodule

// File: rtl/chaos_mix_sel_chk.sv
module chaos_mix_sel_chk #(
  parameter int W    = 32,
  parameter int NSRC = 4,
  localparam int SW  = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [NSRC*W-1:0] x_bus,
  input logic [NSRC*W-1:0] y_bus,
  input logic [NSRC*W-1:0] z_bus,
  input logic [SW-1:0]     sel_x,
  input logic [SW-1:0]     sel_y,
  input logic [SW-1:0]     sel_z,
  input logic [1:0]        sel_out,
  input logic [W-1:0]      key_word,
  input logic              key_valid
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (key_word == '0 && !key_valid));

  p_x_route_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_out == 2'b00) |=> key_word == $past(x_bus[sel_x*W +: W]));

  p_y_route_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_out == 2'b01) |=> key_word == $past(y_bus[sel_y*W +: W]));

  p_z_route_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_out == 2'b10) |=> key_word == $past(z_bus[sel_z*W +: W]));

  p_code3_as_x_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_out == 2'b11) |=> key_word == $past(x_bus[sel_x*W +: W]));

  p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> key_valid);

  p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !key_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(key_word));

endmodule

bind chaos_mix_sel chaos_mix_sel_chk #(.W(W), .NSRC(NSRC)) u_chk (.*);

// File: tb/test_chaos_mix_sel.sv
module test_chaos_mix_sel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NSRC*W-1:0] x_bus = '0, y_bus = '0, z_bus = '0;
  logic [1:0] sel_x = '0, sel_y = '0, sel_z = '0, sel_out = '0;
  logic [W-1:0] key_word;
  logic key_valid;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chaos_mix_sel #(.W(W), .NSRC(NSRC)) i_chaos_mix_sel (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x_bus(x_bus), .y_bus(y_bus), .z_bus(z_bus),
    .sel_x(sel_x), .sel_y(sel_y), .sel_z(sel_z), .sel_out(sel_out),
    .key_word(key_word), .key_valid(key_valid)
  );

  function automatic logic [W-1:0] mk(input int coord, input int src, input int seed);
    return W'((coord << 28) | ((seed & 8'hff) << 8) | src);
  endfunction

  task automatic load_buses(input int seed);
    for (int n = 0; n < NSRC; n++) begin
      x_bus[n*W +: W] = mk(10, n, seed);
      y_bus[n*W +: W] = mk(11, n, seed);
      z_bus[n*W +: W] = mk(12, n, seed);
    end
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] sx, input logic [1:0] sy, input logic [1:0] sz,
                        input logic [1:0] so, input int seed);
    @(negedge clk);
    load_buses(seed);
    sel_x = sx; sel_y = sy; sel_z = sz; sel_out = so;
    in_valid = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset word", key_word, '0);
    check("R1 reset valid", W'(key_valid), W'(0));
  endtask

  task automatic t_x_route();
    for (int i = 0; i < NSRC; i++) begin
      strobe(2'(i), 2'(3-i), 2'(i+1), 2'b00, 16 + i);
      check("R2 x route", key_word, mk(10, i, 16 + i));
      check("R6 valid after strobe", W'(key_valid), W'(1));
    end
    idle();
  endtask

  task automatic t_y_route();
    for (int i = 0; i < NSRC; i++) begin
      strobe(2'(3-i), 2'(i), 2'(i+2), 2'b01, 32 + i);
      check("R3 y route", key_word, mk(11, i, 32 + i));
    end
    idle();
  endtask

  task automatic t_z_route();
    for (int i = 0; i < NSRC; i++) begin
      strobe(2'(i+1), 2'(i+3), 2'(i), 2'b10, 48 + i);
      check("R4 z route", key_word, mk(12, i, 48 + i));
    end
    idle();
  endtask

  task automatic t_code3();
    strobe(2'd2, 2'd1, 2'd0, 2'b11, 64);
    check("R5 code 11 as x", key_word, mk(10, 2, 64));
    strobe(2'd3, 2'd0, 2'd1, 2'b11, 65);
    check("R5 code 11 as x", key_word, mk(10, 3, 65));
    idle();
  endtask

  task automatic t_hold();
    logic [W-1:0] kept;
    strobe(2'd1, 2'd1, 2'd1, 2'b01, 80);
    kept = mk(11, 1, 80);
    check("R7 preload", key_word, kept);
    @(negedge clk);
    in_valid = 1'b0;
    load_buses(81);
    sel_x = 2'd3; sel_y = 2'd2; sel_z = 2'd0; sel_out = 2'b10;
    @(posedge clk); #1;
    check("R6 valid drops", W'(key_valid), W'(0));
    check("R7 hold", key_word, kept);
    @(negedge clk);
    load_buses(82);
    sel_y = 2'd0;
    @(posedge clk); #1;
    check("R7 hold second", key_word, kept);
  endtask

  task automatic t_switch();
    for (int k = 0; k < 8; k++) begin
      strobe(2'(k), 2'(k+1), 2'(k+2), 2'(k % 3), 96 + k);
      case (k % 3)
        0: check("R8 switch x", key_word, mk(10, k % 4, 96 + k));
        1: check("R8 switch y", key_word, mk(11, (k+1) % 4, 96 + k));
        default: check("R8 switch z", key_word, mk(12, (k+2) % 4, 96 + k));
      endcase
    end
    idle();
  endtask

  task automatic t_reset_mid();
    strobe(2'd1, 2'd0, 2'd0, 2'b00, 120);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(posedge clk); #1;
    check("R1 reset over strobe word", key_word, '0);
    check("R1 reset over strobe valid", W'(key_valid), W'(0));
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_x_route();
    t_y_route();
    t_z_route();
    t_code3();
    t_hold();
    t_switch();
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule